// File: doc/BRIEF.md
# Pin Edge Interrupt Detector

This block watches a bank of general-purpose input pins and turns selected pin activity into a single interrupt request. Each pin is first passed through a two-flop synchroniser. A per-pin mode then decides which activity on that pin counts as an event: nothing, a low-to-high transition, a high-to-low transition, or a departure from the value the pin had when the processor last read the port. All per-pin events are merged into one output that pulses high for one clock cycle. That output is meant for an interrupt controller that latches requests on a rising edge.

The processor side is kept minimal. A write strobe loads the mode fields of all pins at once. The synchronised pin values are always visible on a read-data bus. A read strobe marks the moment the processor samples that bus, and at that moment the current synchronised values are latched as the reference for change detection. In change mode a pin raises one event when it starts to differ from that reference. It raises no further event while it stays different. If it drifts back before a read, the event is not repeated.

Top module: `pin_event_irq`

## Requirements
- R1: After synchronous reset the interrupt output is low, the read-data bus is all zeros, every pin is in disabled mode and every change reference is zero.
- R2: A pin value that is held stable appears on the read-data bus after exactly two rising clock edges, and not after one.
- R3: A high write strobe loads all mode fields in one cycle. Pin i uses bits [2i+1:2i] of the write data, with encoding 00 disabled, 01 rising, 10 falling and 11 change. A pin only responds to the mode in its own field.
- R4: In rising mode, a synchronised 0-to-1 transition gives a one-cycle interrupt pulse on the third rising edge after the input changes. A 1-to-0 transition gives nothing.
- R5: In falling mode, a synchronised 1-to-0 transition gives a one-cycle pulse with the same latency as R4. A 0-to-1 transition gives nothing.
- R6: In change mode, a pin gives one pulse (same latency as R4) in the cycle its synchronised value first differs from its reference. No further pulse follows while the difference persists.
- R7: A high read strobe latches the synchronised pin values as the new references. A pin that returns to its reference before a read gives no pulse on its return. After a read, a change away from the newly latched value gives a pulse.
- R8: A pin in disabled mode never causes a pulse, whatever its input does.
- R9: Events on several pins in the same cycle give one single-cycle pulse. Events in consecutive cycles give pulses in consecutive cycles.
- R10: A read strobe in the cycle where a change-mode mismatch first appears still gives that event's pulse. The reference takes the new value, so no further pulse follows until the pin moves again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| cfg_we | input | 1 | Mode write strobe |
| cfg_wdata | input | 2*NUM_PINS | Mode fields, two bits per pin |
| rd_stb | input | 1 | Port read strobe; latches the change references |
| rd_data | output | NUM_PINS | Synchronised pin values |
| irq_pulse | output | 1 | Merged one-cycle interrupt request |

## Verification
Two functions can fall in the same cycle. The first is the snapshot taken by a port read. The second is the change detector noticing a fresh mismatch against the old snapshot. The bench provokes this by raising the read strobe in exactly the cycle the synchronised mismatch first becomes visible. It then requires one pulse on the normal schedule and silence while the pin holds. It also requires a further pulse when the pin returns to its old level, which shows that the snapshot captured the new value. The scoreboard also checks that simultaneous events on several pins merge into one pulse, and that events one cycle apart give back-to-back pulses.

// File: rtl/pin_irq_pkg.sv
// Package: shared types for the pin edge interrupt detector.
// Assumes a two-bit mode field per pin.
package pin_irq_pkg;

    localparam int MODE_W = 2;

    // Per-pin event selection, encoding fixed by the register map
    typedef enum logic [MODE_W-1:0] {
        PM_OFF    = 2'b00,
        PM_RISE   = 2'b01,
        PM_FALL   = 2'b10,
        PM_CHANGE = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherence is promised) and
// STAGES >= 2. Output lags input by STAGES rising edges.
module pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d;
                end
            end else begin : g_rest
                // Later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pin_mode_bank.sv
// Module: pin_mode_bank
// Holds the mode fields of all pins, loaded all at once by a write strobe.
// Assumes writes are whole-word; no partial update is offered.
module pin_mode_bank #(
    parameter int NUM_PINS = 8,
    parameter int MODE_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [NUM_PINS*MODE_W-1:0] wdata,
    output logic [NUM_PINS*MODE_W-1:0] modes
);

    logic [NUM_PINS*MODE_W-1:0] modes_q;

    // Load the mode word on a write; reset to all disabled
    always_ff @(posedge clk) begin
        if (!rst_n)  modes_q <= '0;
        else if (we) modes_q <= wdata;
    end

    assign modes = modes_q;

endmodule

// File: rtl/pin_event_cell.sv
// Module: pin_event_cell
// Event detection for one synchronised pin: rising, falling, or change
// against a reference latched on a port read. The change detector is
// armed when the mismatch begins, so a persistent mismatch fires once.
// Assumes pin_s is already synchronised to clk.
module pin_event_cell
    import pin_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_s,
    input  pin_mode_e mode,
    input  logic      snap_stb,
    output logic      evt
);

    logic prev_q;
    logic ref_q;
    logic mism_q;
    logic mism;
    logic rise;
    logic fall;
    logic chg;

    // Raw detectors, computed every cycle whatever the mode
    always_comb begin
        mism = pin_s ^ ref_q;
        rise = pin_s & ~prev_q;
        fall = ~pin_s & prev_q;
        chg  = mism & ~mism_q;
    end

    // Pick the detector the mode asks for
    always_comb begin
        unique case (mode)
            PM_RISE:   evt = rise;
            PM_FALL:   evt = fall;
            PM_CHANGE: evt = chg;
            default:   evt = 1'b0;
        endcase
    end

    // History: last sample, last mismatch, and the read reference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            mism_q <= 1'b0;
            ref_q  <= 1'b0;
        end else begin
            prev_q <= pin_s;
            mism_q <= mism;
            if (snap_stb) ref_q <= pin_s;
        end
    end

endmodule

// File: rtl/irq_merge.sv
// Module: irq_merge
// ORs the per-pin events and registers the result as a one-cycle request.
// Assumes each event is a single-cycle strobe.
module irq_merge #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt,
    output logic                irq
);

    logic irq_q;

    // Register the merged request so the output is glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |evt;
    end

    assign irq = irq_q;

endmodule

// File: rtl/pin_event_irq.sv
// Module: pin_event_irq (top)
// Bank of pins, each able to raise an interrupt on a selected event,
// merged onto one shared one-cycle request. Assumes rd_stb is asserted
// in the cycle the processor samples rd_data.
module pin_event_irq
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PINS-1:0]        pin_in,
    input  logic                       cfg_we,
    input  logic [NUM_PINS*MODE_W-1:0] cfg_wdata,
    input  logic                       rd_stb,
    output logic [NUM_PINS-1:0]        rd_data,
    output logic                       irq_pulse
);

    localparam int MODE_BITS = NUM_PINS * MODE_W;

    logic [NUM_PINS-1:0]  pin_s;
    logic [MODE_BITS-1:0] modes;
    logic [NUM_PINS-1:0]  evt;

    pin_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    pin_mode_bank #(
        .NUM_PINS (NUM_PINS),
        .MODE_W   (MODE_W)
    ) u_modes (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .modes (modes)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            pin_event_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_s    (pin_s[i]),
                .mode     (pin_mode_e'(modes[i*MODE_W +: MODE_W])),
                .snap_stb (rd_stb),
                .evt      (evt[i])
            );
        end
    endgenerate

    irq_merge #(
        .NUM_PINS (NUM_PINS)
    ) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .irq   (irq_pulse)
    );

    assign rd_data = pin_s;

endmodule

// File: rtl/pin_event_irq_chk.sv
// Module: pin_event_irq_chk
// Property checker for pin_event_irq, attached by bind. Keeps its own
// copy of the mode word taken from the write port.
module pin_event_irq_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   pin_in,
    input logic                  cfg_we,
    input logic [2*NUM_PINS-1:0] cfg_wdata,
    input logic [NUM_PINS-1:0]   rd_data,
    input logic                  irq_pulse
);

    logic [2*NUM_PINS-1:0] mode_sh;
    logic [1:0]            warm_q;
    logic                  all_rise;
    logic                  no_chg;

    // Shadow of the mode word
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_sh <= '0;
        else if (cfg_we) mode_sh <= cfg_wdata;
    end

    // Cycles since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)            warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // Mode summaries
    always_comb begin
        all_rise = 1'b1;
        no_chg   = 1'b1;
        for (int k = 0; k < NUM_PINS; k++) begin
            if (mode_sh[2*k +: 2] != 2'b01) all_rise = 1'b0;
            if (mode_sh[2*k +: 2] == 2'b11) no_chg   = 1'b0;
        end
    end

    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (rd_data == $past(pin_in, 2)));

    assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd1 && all_rise && ((rd_data & ~$past(rd_data)) == '0))
        |=> !irq_pulse);

    assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sh == '0) |=> !irq_pulse);

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd3 && irq_pulse && $past(no_chg))
        |-> ($past(rd_data) != $past(rd_data, 2)));

endmodule

bind pin_event_irq pin_event_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .rd_data   (rd_data),
    .irq_pulse (irq_pulse)
);

// File: tb/sim_pin_event_irq.sv
// Scoreboard bench: drivers push expected pulse cycles, a monitor pops them.
module sim_pin_event_irq;

    localparam int NP = 8;

    typedef struct {
        int    cyc;
        string tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   pins = '0;
    logic            cfg_we = 1'b0;
    logic [2*NP-1:0] cfg_wdata = '0;
    logic            rd_stb = 1'b0;
    logic [NP-1:0]   rd_data;
    logic            irq_pulse;

    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    string phase = "R1";
    exp_t  q[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pin_event_irq #(.NUM_PINS(NP), .SYNC_STAGES(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pins),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .rd_stb    (rd_stb),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    // Monitor: compare the pulse output with the expected queue each cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && q[0].cyc == cyc) begin
                checks++;
                if (!irq_pulse) begin
                    failures++;
                    $display("FAIL %s missing pulse cyc=%0d actual=0 expected=1", q[0].tag, cyc);
                end
                q.delete(0);
            end else if (irq_pulse) begin
                checks++;
                failures++;
                $display("FAIL %s unexpected pulse cyc=%0d actual=1 expected=0", phase, cyc);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: set the pins, and enqueue a pulse three edges later if due
    task automatic drive(logic [NP-1:0] v, bit fire, string tag);
        exp_t e;
        phase = tag;
        pins  = v;
        if (fire) begin
            e.cyc = cyc + 3;
            e.tag = tag;
            q.push_back(e);
        end
        step(1);
    endtask

    task automatic set_modes(logic [2*NP-1:0] w);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        step(1);
        cfg_we    = 1'b0;
    endtask

    task automatic port_read();
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        check_eq("R1 irq after reset", {31'd0, irq_pulse}, 32'd0);
        check_eq("R1 rd_data after reset", {24'd0, rd_data}, 32'd0);

        // R2 latency; R1 modes are off, so no pulse is expected
        drive(8'hFF, 1'b0, "R2");
        check_eq("R2 one edge", {24'd0, rd_data}, 32'd0);
        step(1);
        check_eq("R2 two edges", {24'd0, rd_data}, 32'hFF);
        step(4);
        drive(8'h00, 1'b0, "R1");
        step(6);

        // pin0 rise, pin1 fall, pin2 change, pin3 off, pins4..7 rise
        set_modes(16'h5539);
        step(2);

        drive(8'h01, 1'b1, "R4"); step(6);
        drive(8'h00, 1'b0, "R4"); step(6);
        drive(8'h02, 1'b0, "R5"); step(6);
        drive(8'h00, 1'b1, "R5"); step(6);
        drive(8'h08, 1'b0, "R8"); step(4);
        drive(8'h00, 1'b0, "R8"); step(6);

        // R9: four pins at once give one pulse
        drive(8'hF0, 1'b1, "R9"); step(6);
        drive(8'h00, 1'b0, "R9"); step(6);
        // R9: one cycle apart give back-to-back pulses
        drive(8'h10, 1'b1, "R9");
        drive(8'h30, 1'b1, "R9");
        step(6);
        drive(8'h00, 1'b0, "R9"); step(6);

        // R6: change fires once, holds quiet
        drive(8'h04, 1'b1, "R6"); step(8);
        // R7: revert before read is silent, then a new change fires
        drive(8'h00, 1'b0, "R7"); step(6);
        drive(8'h04, 1'b1, "R6"); step(6);
        port_read();
        check_eq("R7 read value", {24'd0, rd_data}, 32'h04);
        step(3);
        drive(8'h00, 1'b1, "R7"); step(6);
        port_read();
        step(4);

        // R10: read lands in the cycle the mismatch first shows
        drive(8'h04, 1'b1, "R10");
        step(1);
        port_read();
        step(8);
        drive(8'h00, 1'b1, "R10"); step(6);
        port_read();
        step(4);

        // R3: only pin7 in rising mode (bits 15:14 = 01)
        set_modes(16'h4000);
        step(2);
        drive(8'h01, 1'b0, "R3"); step(6);
        drive(8'h81, 1'b1, "R3"); step(6);
        drive(8'h00, 1'b0, "R3"); step(10);

        while (q.size() > 0) begin
            checks++;
            failures++;
            $display("FAIL %s pending pulse cyc=%0d actual=0 expected=1", q[0].tag, q[0].cyc);
            q.delete(0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule